// File: doc/BRIEF.md
# CAN Frame Time Stamp Unit

This block keeps a free-running time base for a CAN controller that stores frames in message buffers, and it supplies each frame with a time stamp. The protocol engine gives a one-cycle strobe when the identifier field of a frame begins on the bus. At that strobe the block latches the current timer value. The latched value later goes into the time stamp field of the message buffer that holds the frame. The block writes it through a narrow write port made of a buffer index, a value and a write strobe.

The point at which the stamp is written depends on the direction of the frame. A received frame gets its stamp in the same step in which the engine reports that the frame has been stored in a receive buffer. A transmitted frame gets its stamp only once the engine reports that the transmission finished without error. A failed or lost transmission drops the capture. When the synchronization option is on, storing a received frame in the designated buffer (buffer 0 by default) clears the timer. Nodes use this to align their time bases across the network. The timer advances once per bit-time enable pulse and stands still while the controller is frozen.

Top module: `can_tstamp_unit`

## Requirements
- R1: After reset `timer_val` is 0x0000 and `ts_wr` is low.
- R2: Each cycle with `tick_en` high and `freeze` low adds one to the timer, and the value wraps from 0xFFFF to 0x0000. Cycles with `tick_en` low leave the timer unchanged.
- R3: While `freeze` is high the timer keeps its value, even when `tick_en` pulses.
- R4: A cycle with `id_start` high captures the value that `timer_val` shows in that same cycle. The capture stays valid until a stamp write consumes it or a transmit failure drops it.
- R5: If `rx_store` is high while a capture is valid, then in the next cycle `ts_wr` is high, `ts_idx` equals `rx_buf` and `ts_val` equals the captured value.
- R6: If `tx_ok` is high while a capture is valid, then in the next cycle `ts_wr` is high, `ts_idx` equals `tx_buf` and `ts_val` equals the captured value. A `tx_fail` pulse drops the capture, so a later `tx_ok` without a new `id_start` produces no write.
- R7: A completion strobe (`rx_store` or `tx_ok`) that arrives with no valid capture produces no write. Each write consumes its capture.
- R8: When `sync_en` is high and `rx_store` is high with `rx_buf` equal to the sync buffer index (0), the timer reads 0x0000 in the next cycle, even if a tick arrives in the same cycle. If `sync_en` is low, or the frame goes to any other buffer, the timer is not cleared.
- R9: Each completion produces a `ts_wr` pulse that lasts one cycle. `ts_wr` is low in the cycle after a write unless a new completion arrived.
- R10: If `rx_store` and `id_start` are high in the same cycle, the write uses the earlier capture, and the new capture is kept for the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Bit-time enable pulse; advances the timer |
| freeze | input | 1 | Controller frozen; timer holds |
| sync_en | input | 1 | Enables the timer clear on reception into the sync buffer |
| id_start | input | 1 | Strobe: identifier field begins on the bus |
| rx_store | input | 1 | Strobe: received frame written into a buffer |
| rx_buf | input | 4 | Index of the receiving buffer |
| tx_ok | input | 1 | Strobe: transmission completed without error |
| tx_fail | input | 1 | Strobe: transmission failed or arbitration lost |
| tx_buf | input | 4 | Index of the transmitting buffer |
| timer_val | output | 16 | Current timer value |
| ts_wr | output | 1 | Time stamp write strobe |
| ts_idx | output | 4 | Buffer index for the time stamp write |
| ts_val | output | 16 | Time stamp value to write |

## Verification
The bench builds the unit with its default 16-bit timer, a 4-bit buffer index, sync buffer 0 and the registered write port (`OUT_REG = 1`). With these settings the write appears exactly one cycle after a completion strobe, and the 16-bit counter can be driven through its full range to the 0xFFFF to 0x0000 wrap in about 65 thousand cycles. Random traffic then mixes ticks, freezes, captures, completions, failures and sync events in the same cycles. This exposes the priority between a sync clear and a tick, and between a capture and a completion.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
   // where a pending stamp write came from
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_RX   = 2'd1,
      SRC_TX   = 2'd2
   } ts_src_e;
endpackage

// File: rtl/tstamp_timer.sv
module tstamp_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             freeze,
   input  logic             sync_clr,
   output logic [TMR_W-1:0] count
);
   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   generate
      if (TMR_W < 2) begin : g_bad_w
         $error("tstamp_timer: TMR_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (sync_clr)
         count <= '0;
      else if (tick_en && !freeze)
         count <= count + ONE;
   end

   AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !freeze && !sync_clr) |=> (count == $past(count) + ONE)); // R2
   AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !sync_clr) |=> $stable(count)); // R3
   AST_TMR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      sync_clr |=> (count == '0)); // R8
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
   import tstamp_pkg::*;
#(
   parameter int TMR_W = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] timer,
   input  logic             id_start,
   input  logic             rx_store,
   input  logic [IDX_W-1:0] rx_buf,
   input  logic             tx_ok,
   input  logic             tx_fail,
   input  logic [IDX_W-1:0] tx_buf,
   output logic             req,
   output logic [IDX_W-1:0] req_idx,
   output logic [TMR_W-1:0] req_val
);
   logic [TMR_W-1:0] cap_q;
   logic             cap_vld;
   ts_src_e          src;

   // receive completion takes precedence; a transmit end in the same cycle is not expected
   always_comb begin
      if (rx_store)   src = SRC_RX;
      else if (tx_ok) src = SRC_TX;
      else            src = SRC_NONE;
   end

   assign req     = cap_vld && (src != SRC_NONE);
   assign req_idx = (src == SRC_RX) ? rx_buf : tx_buf;
   assign req_val = cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q   <= '0;
         cap_vld <= 1'b0;
      end else begin
         if (id_start) begin
            cap_q   <= timer;
            cap_vld <= 1'b1;
         end else if (req || tx_fail) begin
            cap_vld <= 1'b0;
         end
      end
   end

   AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      id_start |=> (cap_vld && cap_q == $past(timer))); // R4
   AST_CAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fail && !id_start) |=> !cap_vld); // R6
   AST_CAP_USED: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !id_start) |=> !cap_vld); // R7
endmodule

// File: rtl/tstamp_writer.sv
module tstamp_writer #(
   parameter int TMR_W   = 16,
   parameter int IDX_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [IDX_W-1:0] req_idx,
   input  logic [TMR_W-1:0] req_val,
   output logic             wr,
   output logic [IDX_W-1:0] wr_idx,
   output logic [TMR_W-1:0] wr_val
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr     <= 1'b0;
               wr_idx <= '0;
               wr_val <= '0;
            end else begin
               wr <= req;
               if (req) begin
                  wr_idx <= req_idx;
                  wr_val <= req_val;
               end
            end
         end

         AST_WR_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            req |=> (wr && wr_idx == $past(req_idx) && wr_val == $past(req_val))); // R5
         AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            !req |=> !wr); // R9
      end else begin : g_comb
         always_comb begin
            wr     = req;
            wr_idx = req_idx;
            wr_val = req_val;
         end
      end
   endgenerate
endmodule

// File: rtl/can_tstamp_unit.sv
module can_tstamp_unit #(
   parameter int TMR_W    = 16,
   parameter int IDX_W    = 4,
   parameter int SYNC_BUF = 0,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             freeze,
   input  logic             sync_en,
   input  logic             id_start,
   input  logic             rx_store,
   input  logic [IDX_W-1:0] rx_buf,
   input  logic             tx_ok,
   input  logic             tx_fail,
   input  logic [IDX_W-1:0] tx_buf,
   output logic [TMR_W-1:0] timer_val,
   output logic             ts_wr,
   output logic [IDX_W-1:0] ts_idx,
   output logic [TMR_W-1:0] ts_val
);
   localparam int NBUF = 1 << IDX_W;
   localparam logic [IDX_W-1:0] SYNC_IDX = IDX_W'(SYNC_BUF);

   generate
      if (SYNC_BUF < 0 || SYNC_BUF >= NBUF) begin : g_bad_sync
         $error("can_tstamp_unit: SYNC_BUF outside the buffer range");
      end
   endgenerate

   logic             sync_clr;
   logic             req;
   logic [IDX_W-1:0] req_idx;
   logic [TMR_W-1:0] req_val;

   assign sync_clr = sync_en && rx_store && (rx_buf == SYNC_IDX);

   tstamp_timer #(.TMR_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .freeze   (freeze),
      .sync_clr (sync_clr),
      .count    (timer_val)
   );

   tstamp_capture #(.TMR_W(TMR_W), .IDX_W(IDX_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .timer    (timer_val),
      .id_start (id_start),
      .rx_store (rx_store),
      .rx_buf   (rx_buf),
      .tx_ok    (tx_ok),
      .tx_fail  (tx_fail),
      .tx_buf   (tx_buf),
      .req      (req),
      .req_idx  (req_idx),
      .req_val  (req_val)
   );

   tstamp_writer #(.TMR_W(TMR_W), .IDX_W(IDX_W), .OUT_REG(OUT_REG)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .req_idx (req_idx),
      .req_val (req_val),
      .wr      (ts_wr),
      .wr_idx  (ts_idx),
      .wr_val  (ts_val)
   );

   AST_SYNC_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_en && rx_store && rx_buf == SYNC_IDX) |=> (timer_val == '0)); // R8
   AST_FAIL_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
      (OUT_REG && tx_fail && !rx_store && !tx_ok) |=> !ts_wr); // R6
endmodule

// File: tb/can_tstamp_unit_test.sv
`timescale 1ns/1ps
module can_tstamp_unit_test;
   localparam int TW = 16;
   localparam int IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 0, freeze = 0, sync_en = 0, id_start = 0;
   logic rx_store = 0, tx_ok = 0, tx_fail = 0;
   logic [IW-1:0] rx_buf = '0, tx_buf = '0;
   logic [TW-1:0] timer_val, ts_val;
   logic          ts_wr;
   logic [IW-1:0] ts_idx;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   logic [TW-1:0] m_tmr = '0, m_cap = '0, m_val = '0;
   logic          m_cv = 0, m_wr = 0;
   logic [IW-1:0] m_idx = '0;

   always #2.5 clk = ~clk;

   can_tstamp_unit #(.TMR_W(TW), .IDX_W(IW), .SYNC_BUF(0), .OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
      .sync_en(sync_en), .id_start(id_start), .rx_store(rx_store),
      .rx_buf(rx_buf), .tx_ok(tx_ok), .tx_fail(tx_fail), .tx_buf(tx_buf),
      .timer_val(timer_val), .ts_wr(ts_wr), .ts_idx(ts_idx), .ts_val(ts_val)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
      end
   endtask

   // model step from the requirements, old values on the right
   function automatic void model_step();
      logic sync, req;
      sync = sync_en && rx_store && (rx_buf == '0);
      req  = m_cv && (rx_store || tx_ok);
      m_wr = req;
      if (req) begin
         m_idx = rx_store ? rx_buf : tx_buf;
         m_val = m_cap;
      end
      if (id_start) begin
         m_cap = m_tmr;
         m_cv  = 1'b1;
      end else if (req || tx_fail) begin
         m_cv = 1'b0;
      end
      if (sync) m_tmr = '0;
      else if (tick_en && !freeze) m_tmr = m_tmr + 1'b1;
   endfunction

   // one cycle: inputs already driven at a falling edge
   task automatic cyc(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(tag, "timer", 32'(timer_val), 32'(m_tmr));
      chk(tag, "wr", 32'(ts_wr), 32'(m_wr));
      if (m_wr) begin
         chk(tag, "idx", 32'(ts_idx), 32'(m_idx));
         chk(tag, "val", 32'(ts_val), 32'(m_val));
      end
   endtask

   task automatic idle();
      tick_en = 0; freeze = 0; id_start = 0; rx_store = 0;
      tx_ok = 0; tx_fail = 0;
   endtask

   initial begin
      #(5.0 * 300000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C4A));
      repeat (3) @(negedge clk);
      chk("R1", "timer", 32'(timer_val), 32'h0);
      chk("R1", "wr", 32'(ts_wr), 32'h0);
      rst_n = 1'b1;

      // R2 counting, gaps without tick
      for (int i = 0; i < 30; i++) begin
         tick_en = (i % 3 != 0);
         cyc("R2");
      end
      // R3 frozen
      tick_en = 1; freeze = 1;
      for (int i = 0; i < 8; i++) cyc("R3");
      idle();
      // R4/R5 receive stamp into buffer 3
      tick_en = 1; id_start = 1; cyc("R4");
      id_start = 0;
      for (int i = 0; i < 5; i++) cyc("R4");
      rx_store = 1; rx_buf = 4'd3; cyc("R5");
      rx_store = 0; cyc("R9");
      // R6 failure drops capture
      id_start = 1; cyc("R6"); id_start = 0;
      tx_fail = 1; cyc("R6"); tx_fail = 0;
      tx_ok = 1; tx_buf = 4'd9; cyc("R6"); tx_ok = 0;
      cyc("R6");
      id_start = 1; cyc("R6"); id_start = 0;
      cyc("R6");
      tx_ok = 1; cyc("R6"); tx_ok = 0;
      cyc("R9");
      // R7 completion without capture, and second use of a consumed capture
      rx_store = 1; rx_buf = 4'd7; cyc("R7");
      cyc("R7");
      rx_store = 0;
      // R10 capture and completion together
      id_start = 1; cyc("R10");
      rx_store = 1; rx_buf = 4'd12; cyc("R10");
      id_start = 0; cyc("R10");
      rx_store = 0; cyc("R10");
      // R8 sync clear with a coincident tick
      sync_en = 1; tick_en = 1;
      id_start = 1; cyc("R8"); id_start = 0;
      cyc("R8");
      rx_store = 1; rx_buf = 4'd0; cyc("R8"); rx_store = 0;
      chk("R8", "timer_zero", 32'(timer_val), 32'h0);
      cyc("R8");
      rx_store = 1; rx_buf = 4'd4; cyc("R8"); rx_store = 0;
      sync_en = 0;
      rx_store = 1; rx_buf = 4'd0; cyc("R8"); rx_store = 0;
      // R2 full range and wrap
      tick_en = 1;
      while (m_tmr != 16'hFFFF) cyc("R2");
      cyc("R2");
      chk("R2", "wrap", 32'(timer_val), 32'h0);
      idle();
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int ev;
         idle();
         tick_en = ($urandom % 4) != 0;
         freeze  = ($urandom % 10) == 0;
         sync_en = ($urandom % 2) == 0;
         id_start = ($urandom % 6) == 0;
         ev = $urandom % 8;
         rx_buf = IW'($urandom % 3 == 0 ? 0 : $urandom);
         tx_buf = IW'($urandom);
         if (ev == 0) rx_store = 1;
         else if (ev == 1) tx_ok = 1;
         else if (ev == 2) tx_fail = 1;
         cyc("R5");
      end
      idle();
      cyc("R9");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule